// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit turns an instruction's addressing fields into a 16-bit effective address for a small processor core. The caller presents a 4-bit mode code, a register selector, an 8-bit displacement, a 2-bit scale code, the program counter and a flat copy of the register bank, and pulses `start` for one cycle. All fields are captured on that edge. The result comes back on `ea` with a one-cycle `done` strobe. For the auto-update modes it also asks for a register write-back through `wbEn` and `wbData`; the register to update is the one that `regSel` named.

The two memory-indirect modes fetch a 16-bit pointer over a byte-wide synchronous read port, low byte first. The pre-indexed form adds the index register before the fetch. The post-indexed form adds it to the fetched pointer. Register 0 always reads as zero, whatever its bank slice holds. The displacement is sign-extended to 16 bits, and every sum wraps modulo 2^16.

Top module: `ea_unit`

## Requirements
- R1: While `rstN` is low and after its release, `done`, `wbEn` and `memRd` are 0 and `ea` is 0.
- R2: Mode 1 (indexed) gives ea = R + sext(disp). `done` rises in the second cycle after the `start` edge. Mode 0 (register indirect) and the unused codes 11 to 15 give ea = R, which is mode 1 with disp = 0.
- R3: Mode 2 (base plus offset) gives R + sext(disp). With `regSel` = 0 the result is sext(disp) alone, because register 0 reads as zero.
- R4: Mode 3 (PC-relative) gives pc + sext(disp).
- R5: Mode 4 (scaled index) gives (R shifted left by `scale`) + sext(disp), so the multiplier is 1, 2, 4 or 8 for scale codes 0 to 3.
- R6: Modes 5 (pre-increment) and 7 (pre-decrement) use step = 1 << scale. ea and `wbData` are both R + step or R - step, and `wbEn` pulses with `done`.
- R7: Modes 6 (post-increment) and 8 (post-decrement) give ea = R, with `wbData` = R + step or R - step and `wbEn` pulsed with `done`.
- R8: `wbEn` is 1 only together with `done`, only in modes 5 to 8, and never when `regSel` = 0.
- R9: Mode 9 (pre-indexed indirect) reads bytes at P = R + sext(disp) and then at P + 1, one cycle apart, with the low byte first. ea = {byte(P+1), byte(P)}, and `done` comes in the fourth cycle after `start`.
- R10: Mode 10 (post-indexed indirect) reads the pointer at P = sext(disp) in the same way and gives ea = pointer + R.
- R11: A `start` pulse that arrives while an operation is in progress is ignored. It causes no extra read and no extra `done`, and `ea` changes only in a cycle where `done` is 1.
- R12: All sums wrap modulo 2^16. This includes the second pointer byte address, so FFFF is followed by 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request that captures all fields |
| mode | input | 4 | Addressing mode code |
| regSel | input | 3 | Register selector; 0 reads as zero |
| disp | input | 8 | Signed displacement or pointer location |
| scale | input | 2 | Scale or step code |
| pc | input | 16 | Program counter |
| regBank | input | 128 | Register bank, register i at bits [16i+15:16i] |
| ea | output | 16 | Effective address, held between results |
| done | output | 1 | Result strobe |
| wbEn | output | 1 | Write-back request |
| wbData | output | 16 | Updated register value |
| memAddr | output | 16 | Byte read address |
| memRd | output | 1 | Byte read request |
| memRdata | input | 8 | Read data, valid the cycle after the request |

## Verification
The bench goes after the places where an address unit tends to go wrong. It places a pointer at FFFF, where a design without wraparound on the second byte would read from 10000 truncated wrongly or from the wrong page. It checks the byte order of the pointer: swapped bytes give a mirrored address. It contrasts the pre and post update forms: confusing them puts the new value on `ea` or the old one on `wbData`. It also reads register 0 with a non-zero bank slice behind it, which would leak into the absolute result. A second `start` is pulsed in the middle of an indirect fetch. A design that restarts on it would issue extra reads, lose the original result or emit a second `done`.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    MD_REGIND  = 4'd0,
    MD_INDEXED = 4'd1,
    MD_BASEOFF = 4'd2,
    MD_PCREL   = 4'd3,
    MD_SCALED  = 4'd4,
    MD_PREINC  = 4'd5,
    MD_POSTINC = 4'd6,
    MD_PREDEC  = 4'd7,
    MD_POSTDEC = 4'd8,
    MD_PREIND  = 4'd9,
    MD_POSTIND = 4'd10
  } eaMode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;         // capture request fields
    logic rdLo;         // issue low pointer byte read
    logic rdHi;         // issue high pointer byte read
    logic capLo;        // store returned low byte
    logic finDirect;    // commit an arithmetic result
    logic finIndirect;  // commit a pointer-based result
  } ctrlStrobe_t;

  function automatic logic isIndirect(input logic [3:0] m);
    return (m == 4'(MD_PREIND)) || (m == 4'(MD_POSTIND));
  endfunction

endpackage

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int RSW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [3:0]        mode,
  input  logic [RSW-1:0]    regSel,
  input  logic [DW-1:0]     disp,
  input  logic [1:0]        scale,
  input  logic [AW-1:0]     pc,
  input  logic [NREG*AW-1:0] regBank,
  input  logic [7:0]        memRdata,
  output logic [AW-1:0]     ea,
  output logic              done,
  output logic              wbEn,
  output logic [AW-1:0]     wbData,
  output logic [AW-1:0]     memAddr,
  output logic              memRd
);

  localparam int EXT = AW - DW;

  logic [AW-1:0] bankArr [NREG];
  logic [AW-1:0] selVal;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_unpack
    assign bankArr[gi] = regBank[gi*AW +: AW];
  end

  assign selVal = (regSel == '0) ? '0 : bankArr[regSel];

  // Captured request
  eaMode_e       modeQ;
  logic [AW-1:0] regQ;
  logic [AW-1:0] pcQ;
  logic [DW-1:0] dispQ;
  logic [1:0]    scaleQ;
  logic          selZeroQ;
  logic [7:0]    loQ;

  logic [AW-1:0] dispX;
  logic [AW-1:0] stepV;
  logic [AW-1:0] incV;
  logic [AW-1:0] decV;
  logic [AW-1:0] offSum;
  logic [AW-1:0] scaledSum;
  logic [AW-1:0] pcSum;
  logic [AW-1:0] directEa;
  logic [AW-1:0] directWb;
  logic          directWbEn;
  logic [AW-1:0] ptrAddr;
  logic [AW-1:0] ptrVal;
  logic [AW-1:0] indEa;

  assign dispX     = {{EXT{dispQ[DW-1]}}, dispQ};
  assign stepV     = AW'(1) << scaleQ;
  assign incV      = regQ + stepV;
  assign decV      = regQ - stepV;
  assign offSum    = regQ + dispX;
  assign scaledSum = (regQ << scaleQ) + dispX;
  assign pcSum     = pcQ + dispX;

  always_comb begin
    directEa   = regQ;
    directWb   = regQ;
    directWbEn = 1'b0;
    case (modeQ)
      MD_INDEXED, MD_BASEOFF: directEa = offSum;
      MD_PCREL:               directEa = pcSum;
      MD_SCALED:              directEa = scaledSum;
      MD_PREINC: begin
        directEa   = incV;
        directWb   = incV;
        directWbEn = 1'b1;
      end
      MD_POSTINC: begin
        directWb   = incV;
        directWbEn = 1'b1;
      end
      MD_PREDEC: begin
        directEa   = decV;
        directWb   = decV;
        directWbEn = 1'b1;
      end
      MD_POSTDEC: begin
        directWb   = decV;
        directWbEn = 1'b1;
      end
      default: directEa = regQ;
    endcase
  end

  // Pointer location: index applied before the fetch only in pre-indexed form
  assign ptrAddr = (modeQ == MD_PREIND) ? offSum : dispX;
  assign memAddr = stb.rdHi ? ptrAddr + AW'(1) : ptrAddr;
  assign memRd   = stb.rdLo | stb.rdHi;

  assign ptrVal = AW'({memRdata, loQ});
  assign indEa  = (modeQ == MD_POSTIND) ? ptrVal + regQ : ptrVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MD_REGIND;
      regQ     <= '0;
      pcQ      <= '0;
      dispQ    <= '0;
      scaleQ   <= '0;
      selZeroQ <= 1'b1;
      loQ      <= '0;
    end else begin
      if (stb.load) begin
        modeQ    <= eaMode_e'(mode);
        regQ     <= selVal;
        pcQ      <= pc;
        dispQ    <= disp;
        scaleQ   <= scale;
        selZeroQ <= (regSel == '0);
      end
      if (stb.capLo) loQ <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ea     <= '0;
      done   <= 1'b0;
      wbEn   <= 1'b0;
      wbData <= '0;
    end else begin
      done <= stb.finDirect | stb.finIndirect;
      wbEn <= 1'b0;
      if (stb.finDirect) begin
        ea     <= directEa;
        wbEn   <= directWbEn & ~selZeroQ;
        wbData <= directWb;
      end else if (stb.finIndirect) begin
        ea <= indEa;
      end
    end
  end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  mode,
  output ctrlStrobe_t stb,
  output logic        busy
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_RDLO,
    ST_RDHI,
    ST_LAST
  } state_e;

  state_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (start) nextState = isIndirect(mode) ? ST_RDLO : ST_CALC;
      ST_CALC: nextState = ST_IDLE;
      ST_RDLO: nextState = ST_RDHI;
      ST_RDHI: nextState = ST_LAST;
      ST_LAST: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb             = '0;
    stb.load        = (state == ST_IDLE) && start;
    stb.rdLo        = (state == ST_RDLO);
    stb.rdHi        = (state == ST_RDHI);
    stb.capLo       = (state == ST_RDHI);
    stb.finDirect   = (state == ST_CALC);
    stb.finIndirect = (state == ST_LAST);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int RSW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [3:0]         mode,
  input  logic [RSW-1:0]     regSel,
  input  logic [DW-1:0]      disp,
  input  logic [1:0]         scale,
  input  logic [AW-1:0]      pc,
  input  logic [NREG*AW-1:0] regBank,
  output logic [AW-1:0]      ea,
  output logic               done,
  output logic               wbEn,
  output logic [AW-1:0]      wbData,
  output logic [AW-1:0]      memAddr,
  output logic               memRd,
  input  logic [7:0]         memRdata
);

  ctrlStrobe_t stb;
  logic        busy;

  ea_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .stb   (stb),
    .busy  (busy)
  );

  ea_datapath #(.AW(AW), .DW(DW), .NREG(NREG)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .mode     (mode),
    .regSel   (regSel),
    .disp     (disp),
    .scale    (scale),
    .pc       (pc),
    .regBank  (regBank),
    .memRdata (memRdata),
    .ea       (ea),
    .done     (done),
    .wbEn     (wbEn),
    .wbData   (wbData),
    .memAddr  (memAddr),
    .memRd    (memRd)
  );

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [3:0]    mode,
  input logic          busy,
  input logic          done,
  input logic          wbEn,
  input logic          memRd,
  input logic [AW-1:0] memAddr,
  input logic [AW-1:0] ea
);

  assert_direct_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !isIndirect(mode)) |-> ##2 done);

  assert_indirect_issue_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && isIndirect(mode)) |=> memRd);

  assert_no_read_at_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && memRd));

  assert_second_byte_addr_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> (memAddr == AW'($past(memAddr) + 1)));

  assert_wb_needs_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> done);

  assert_ea_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(ea));

  assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .mode    (mode),
  .busy    (busy),
  .done    (done),
  .wbEn    (wbEn),
  .memRd   (memRd),
  .memAddr (memAddr),
  .ea      (ea)
);

// File: tb/tb_ea_unit.sv
module tb_ea_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NREG = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [3:0]        mode = '0;
  logic [2:0]        regSel = '0;
  logic [7:0]        disp = '0;
  logic [1:0]        scale = '0;
  logic [AW-1:0]     pc = '0;
  logic [NREG*AW-1:0] regBank;
  logic [AW-1:0]     ea;
  logic              done;
  logic              wbEn;
  logic [AW-1:0]     wbData;
  logic [AW-1:0]     memAddr;
  logic              memRd;
  logic [7:0]        memRdata = '0;

  logic [AW-1:0] rv [NREG];

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [AW-1:0] ea;
    logic          wbEn;
    logic [AW-1:0] wbData;
    string         req;
  } exp_t;

  exp_t          expQ [$];
  logic [AW-1:0] addrQ [$];
  string         addrReqQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NREG; i++) regBank[i*AW +: AW] = rv[i];
  end

  ea_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .regSel(regSel),
    .disp(disp), .scale(scale), .pc(pc), .regBank(regBank), .ea(ea),
    .done(done), .wbEn(wbEn), .wbData(wbData), .memAddr(memAddr),
    .memRd(memRd), .memRdata(memRdata)
  );

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // Byte memory with one cycle of read latency
  always @(posedge clk) if (memRd) memRdata <= memByte(memAddr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] expv);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Monitor: compares outputs against the scoreboard queues
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memRd) begin
        if (addrQ.size() == 0)
          check(1'b0, "R11", "unexpected read", memAddr, '0);
        else begin
          logic [AW-1:0] ea0;
          string r0;
          ea0 = addrQ.pop_front();
          r0 = addrReqQ.pop_front();
          check(memAddr == ea0, r0, "read address", memAddr, ea0);
        end
      end
      if (done) begin
        if (expQ.size() == 0)
          check(1'b0, "R11", "unexpected done", ea, '0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          check(ea == e.ea, e.req, "ea", ea, e.ea);
          check(wbEn == e.wbEn, "R8", {e.req, " wbEn"}, AW'(wbEn), AW'(e.wbEn));
          if (e.wbEn)
            check(wbData == e.wbData, e.req, "wbData", wbData, e.wbData);
        end
      end else begin
        if (wbEn) check(1'b0, "R8", "wbEn without done", AW'(wbEn), '0);
      end
    end
  end

  // Driver: computes the expected result from the requirements and runs one request
  task automatic run(input logic [3:0] m, input logic [2:0] sel, input logic [7:0] d,
                     input logic [1:0] sc, input string req, input bit intrude);
    exp_t e;
    logic [AW-1:0] r, dx, st, p, ptr;
    int cnt, latExp;
    bit ind;
    r  = (sel == 0) ? '0 : rv[sel];
    dx = {{8{d[7]}}, d};
    st = AW'(1) << sc;
    e.req = req;
    e.wbEn = 1'b0;
    e.wbData = '0;
    ind = 1'b0;
    case (m)
      4'd1, 4'd2: e.ea = r + dx;
      4'd3:       e.ea = pc + dx;
      4'd4:       e.ea = (r << sc) + dx;
      4'd5: begin e.ea = r + st; e.wbData = r + st; e.wbEn = (sel != 0); end
      4'd6: begin e.ea = r;      e.wbData = r + st; e.wbEn = (sel != 0); end
      4'd7: begin e.ea = r - st; e.wbData = r - st; e.wbEn = (sel != 0); end
      4'd8: begin e.ea = r;      e.wbData = r - st; e.wbEn = (sel != 0); end
      4'd9, 4'd10: begin
        ind = 1'b1;
        p = (m == 4'd9) ? r + dx : dx;
        ptr = {memByte(p + 16'd1), memByte(p)};
        e.ea = (m == 4'd10) ? ptr + r : ptr;
        addrQ.push_back(p);          addrReqQ.push_back(req);
        addrQ.push_back(p + 16'd1);  addrReqQ.push_back(req);
      end
      default: e.ea = r;
    endcase
    expQ.push_back(e);
    latExp = ind ? 4 : 2;
    mode = m; regSel = sel; disp = d; scale = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = 4'd0; regSel = 3'd7; disp = 8'hAA; scale = 2'd3;
    cnt = 1;
    while (!done && cnt < 20) begin
      if (intrude && cnt == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    check(cnt == latExp, req, "latency", AW'(cnt), AW'(latExp));
    @(negedge clk);
  endtask

  initial begin
    rv[0] = 16'h7777; rv[1] = 16'h0100; rv[2] = 16'h2000; rv[3] = 16'h0A50;
    rv[4] = 16'hF000; rv[5] = 16'hFFFE; rv[6] = 16'h0001; rv[7] = 16'hFFFF;
    pc = 16'h1234;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !wbEn && !memRd && ea == '0, "R1", "reset outputs",
          {done, wbEn, memRd, 13'd0} | ea, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !wbEn && !memRd && ea == '0, "R1", "after release",
          {done, wbEn, memRd, 13'd0} | ea, '0);

    run(4'd1, 3'd3, 8'h10, 2'd0, "R2", 1'b0);   // 0A60
    run(4'd1, 3'd3, 8'h00, 2'd0, "R2", 1'b0);   // same as indirect
    run(4'd0, 3'd3, 8'h44, 2'd0, "R2", 1'b0);
    run(4'd13, 3'd2, 8'h44, 2'd0, "R2", 1'b0);  // unused code acts as indirect
    run(4'd1, 3'd1, 8'hF0, 2'd0, "R2", 1'b0);   // negative displacement
    run(4'd2, 3'd0, 8'h85, 2'd0, "R3", 1'b0);   // FF85, zero register
    run(4'd2, 3'd2, 8'h7F, 2'd0, "R3", 1'b0);
    run(4'd3, 3'd0, 8'hF0, 2'd0, "R4", 1'b0);   // 1224
    for (int s = 0; s < 4; s++)
      run(4'd4, 3'd3, 8'h03, 2'(s), "R5", 1'b0);
    run(4'd4, 3'd4, 8'h10, 2'd3, "R12", 1'b0);  // F000*8 wraps
    run(4'd5, 3'd1, 8'h00, 2'd1, "R6", 1'b0);
    run(4'd7, 3'd6, 8'h00, 2'd2, "R6", 1'b0);   // 0001-4 wraps
    run(4'd6, 3'd5, 8'h00, 2'd1, "R7", 1'b0);   // FFFE+2 -> 0000
    run(4'd8, 3'd2, 8'h00, 2'd3, "R7", 1'b0);
    run(4'd5, 3'd0, 8'h00, 2'd2, "R8", 1'b0);   // no write-back to register 0
    run(4'd9, 3'd2, 8'h10, 2'd0, "R9", 1'b0);
    run(4'd9, 3'd7, 8'h00, 2'd0, "R12", 1'b0);  // pointer at FFFF, then 0000
    run(4'd10, 3'd3, 8'hC0, 2'd0, "R10", 1'b0);
    run(4'd10, 3'd1, 8'h22, 2'd0, "R10", 1'b0);
    run(4'd9, 3'd1, 8'h08, 2'd0, "R11", 1'b1);  // second start while busy
    repeat (6) @(negedge clk);
    check(expQ.size() == 0 && addrQ.size() == 0, "R11", "queues drained",
          AW'(expQ.size() + addrQ.size()), '0);
    run(4'd1, 3'd3, 8'h01, 2'd0, "R11", 1'b0);  // unit still usable afterwards

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule